// File: doc/BRIEF.md
# Six-Bit Monitoring Word Change Detector

This block watches the six-bit monitoring word (A, E and S1 to S4 bits) that sits in one timeslot of each of sixteen line channels. The channels are spread over two time-division multiplexes with eight channels each. On each multiplex, channel n uses timeslot 4n+3. A new word counts only when it arrives unchanged in two back-to-back frames and also differs from the word last accepted for that channel. An accepted word is written out on a one-cycle storage strobe together with its channel number. The write then sets a sticky pending bit, and the pending bit drives a maskable interrupt.

The receive path presents one slot byte per cycle at most. It gives the timeslot index, the multiplex it came from and a validity strobe, and it pulses a frame marker at the start of every frame. A global validation enable switches all sixteen detections on or off together. Software reads the pending vector and clears its bits with write-one-to-clear pulses.

A small store sequencer orders the work. Its states are OFF (detection disabled), IDLE (waiting) and STORE (write strobe active). Its transitions are OFF to IDLE when enabled, IDLE to STORE on an accepted word, STORE to STORE on a further accepted word, STORE to IDLE otherwise, and any state to OFF when the enable drops.

Top module: `gsw_monitor`

## Requirements
- R1: A slot byte with `slot_idx` equal to 4n+3 (n = 0..7) on multiplex m (`mux_sel`) feeds channel 8m+n. Slot bytes at every other index have no effect on any channel.
- R2: The monitored word is `slot_data[7:2]`. Bits 1:0 of the slot byte are ignored.
- R3: A word is accepted only when the channel received the same word in the previous frame. Frames are delimited by `frame_sync`. A frame in which the channel received nothing breaks the pair, and so does an alternating value.
- R4: A word equal to the last accepted word of its channel is not accepted again. After reset the last accepted word of every channel is 0.
- R5: An acceptance produces exactly one cycle of `st_wr`, in the cycle after the second matching sample, with `st_chan` giving the channel and `st_word` giving the word.
- R6: While `enable` is 0, no channel accepts, no write occurs, no pending bit is set, and samples received are not remembered. After `enable` returns to 1, two further matching frames are needed.
- R7: A pending bit is set in the cycle after its `st_wr`. It stays set until `clr_valid` is pulsed with that bit set in `clr_bits`. A set in the same cycle as a clear wins.
- R8: `irq` is the OR of the pending bits whose `irq_mask` bit is 0. A mask bit blocks only the interrupt; it does not block the write or the pending bit.
- R9: After reset, `st_wr`, `pending` and `irq` are 0.
- R10: Acceptances on consecutive cycles, for example channel n of multiplex 0 followed by channel n of multiplex 1, each produce their own write in consecutive cycles (STORE to STORE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global validation enable for all detections |
| frame_sync | input | 1 | One-cycle pulse marking the start of a frame |
| slot_valid | input | 1 | Slot byte present this cycle |
| slot_idx | input | 5 | Timeslot index of the byte |
| mux_sel | input | 1 | Multiplex the byte came from |
| slot_data | input | 8 | Received slot byte |
| irq_mask | input | 16 | Per-channel interrupt mask, 1 = masked |
| clr_valid | input | 1 | Write-one-to-clear strobe for pending bits |
| clr_bits | input | 16 | Pending bits to clear |
| st_wr | output | 1 | Storage write strobe |
| st_chan | output | 4 | Channel number of the write |
| st_word | output | 6 | Accepted six-bit word |
| pending | output | 16 | Sticky per-channel pending status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a write never follows a cycle with detection disabled, and that at most one channel accepts at a time. They also check that every write leaves its channel pending, that a pending bit only rises after a write to that channel, and that the interrupt is never raised without a pending bit. Whether the right word reaches the right channel only after two consecutive frames can be shown only by the bench's frame sequences. The same holds for a steady value not being accepted twice, for a missing frame breaking the pair, and for samples taken while disabled being forgotten.

// File: rtl/gsw_pkg.sv
package gsw_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_STORE = 2'd2
    } store_state_e;
endpackage

// File: rtl/gsw_chan_filter.sv
module gsw_chan_filter #(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_sync,
    input  logic              hit,
    input  logic [WORD_W-1:0] word,
    output logic              accept
);
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] last_q;
    logic              prev_ok_q;
    logic              got_cur_q;
    logic              pair_ok;

    // at a frame boundary the frame that just ended becomes "previous"
    assign pair_ok = frame_sync ? got_cur_q : prev_ok_q;
    assign accept  = enable && hit && pair_ok && (prev_q == word) && (word != last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            last_q    <= '0;
            prev_ok_q <= 1'b0;
            got_cur_q <= 1'b0;
        end else if (!enable) begin
            prev_ok_q <= 1'b0;
            got_cur_q <= 1'b0;
        end else begin
            if (frame_sync) begin
                prev_ok_q <= got_cur_q;
                got_cur_q <= hit;
            end else if (hit) begin
                got_cur_q <= 1'b1;
            end
            if (hit)    prev_q <= word;
            if (accept) last_q <= word;
        end
    end
endmodule

// File: rtl/gsw_store_fsm.sv
module gsw_store_fsm
    import gsw_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              acc_any,
    input  logic [CH_W-1:0]   acc_chan,
    input  logic [WORD_W-1:0] acc_word,
    output logic              st_wr,
    output logic [CH_W-1:0]   st_chan,
    output logic [WORD_W-1:0] st_word
);
    store_state_e state_q, state_d;
    logic [CH_W-1:0]   chan_q;
    logic [WORD_W-1:0] word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (enable) state_d = acc_any ? ST_STORE : ST_IDLE;
            ST_IDLE:  if (!enable) state_d = ST_OFF;
                      else if (acc_any) state_d = ST_STORE;
            ST_STORE: if (!enable) state_d = ST_OFF;
                      else state_d = acc_any ? ST_STORE : ST_IDLE;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            chan_q  <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (acc_any) begin
                chan_q <= acc_chan;
                word_q <= acc_word;
            end
        end
    end

    always_comb begin
        st_wr   = (state_q == ST_STORE);
        st_chan = chan_q;
        st_word = word_q;
    end

    AST_STORE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |-> $past(enable)) else $error("store without enable"); // R6
endmodule

// File: rtl/gsw_pend_reg.sv
module gsw_pend_reg #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr,
    input  logic [CH_W-1:0]   st_chan,
    input  logic              clr_valid,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] irq_mask,
    output logic [NUM_CH-1:0] pending,
    output logic              irq
);
    logic [NUM_CH-1:0] set_vec;
    logic [NUM_CH-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        if (st_wr) set_vec[st_chan] = 1'b1;
        clr_vec = clr_valid ? clr_bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_vec) | set_vec;
    end

    assign irq = |(pending & ~irq_mask);

    AST_PEND_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> pending[$past(st_chan)]) else $error("write left no pending"); // R7

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pending != '0)) else $error("irq without pending"); // R8

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pchk
        AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[g]) |-> $past(st_wr && (st_chan == CH_W'(g))))
            else $error("pending rose without write"); // R7
    end
endmodule

// File: rtl/gsw_monitor.sv
module gsw_monitor #(
    parameter int SLOT_W  = 5,
    parameter int WORD_W  = 6,
    parameter int NUM_MUX = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  enable,
    input  logic                                  frame_sync,
    input  logic                                  slot_valid,
    input  logic [SLOT_W-1:0]                     slot_idx,
    input  logic [$clog2(NUM_MUX)-1:0]            mux_sel,
    input  logic [WORD_W+1:0]                     slot_data,
    input  logic [NUM_MUX*(2**SLOT_W/4)-1:0]      irq_mask,
    input  logic                                  clr_valid,
    input  logic [NUM_MUX*(2**SLOT_W/4)-1:0]      clr_bits,
    output logic                                  st_wr,
    output logic [$clog2(NUM_MUX*(2**SLOT_W/4))-1:0] st_chan,
    output logic [WORD_W-1:0]                     st_word,
    output logic [NUM_MUX*(2**SLOT_W/4)-1:0]      pending,
    output logic                                  irq
);
    localparam int CH_PER_MUX = (2**SLOT_W) / 4;
    localparam int NUM_CH     = NUM_MUX * CH_PER_MUX;
    localparam int CH_W       = $clog2(NUM_CH);

    logic [WORD_W-1:0] rx_word;
    logic              unused_low_bits;
    logic              slot_hit;
    logic [CH_W-1:0]   slot_chan;
    logic [NUM_CH-1:0] hit_vec;
    logic [NUM_CH-1:0] accept_vec;
    logic              acc_any;
    logic [CH_W-1:0]   acc_chan;

    assign rx_word         = slot_data[WORD_W+1:2];
    assign unused_low_bits = ^slot_data[1:0];
    assign slot_hit        = slot_valid && (slot_idx[1:0] == 2'b11);
    assign slot_chan       = {mux_sel, slot_idx[SLOT_W-1:2]};

    always_comb begin
        hit_vec = '0;
        if (slot_hit) hit_vec[slot_chan] = 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gsw_chan_filter #(.WORD_W(WORD_W)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (enable),
            .frame_sync(frame_sync),
            .hit       (hit_vec[c]),
            .word      (rx_word),
            .accept    (accept_vec[c])
        );
    end

    always_comb begin
        acc_chan = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (accept_vec[i]) acc_chan = CH_W'(i);
    end
    assign acc_any = |accept_vec;

    gsw_store_fsm #(.CH_W(CH_W), .WORD_W(WORD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .acc_any (acc_any),
        .acc_chan(acc_chan),
        .acc_word(rx_word),
        .st_wr   (st_wr),
        .st_chan (st_chan),
        .st_word (st_word)
    );

    gsw_pend_reg #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_wr    (st_wr),
        .st_chan  (st_chan),
        .clr_valid(clr_valid),
        .clr_bits (clr_bits),
        .irq_mask (irq_mask),
        .pending  (pending),
        .irq      (irq)
    );

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept_vec)) else $error("two channels accepted at once"); // R1
endmodule

// File: tb/gsw_monitor_bench.sv
module gsw_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        frame_sync = 1'b0;
    logic        slot_valid = 1'b0;
    logic [4:0]  slot_idx = '0;
    logic [0:0]  mux_sel = '0;
    logic [7:0]  slot_data = '0;
    logic [15:0] irq_mask = '0;
    logic        clr_valid = 1'b0;
    logic [15:0] clr_bits = '0;
    logic        st_wr;
    logic [3:0]  st_chan;
    logic [5:0]  st_word;
    logic [15:0] pending;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt [16];
    int wr_word[16];
    int exp_cnt[16];
    int exp_word[16];
    logic [5:0] cur_w[16];
    logic [3:0] prev_chan;
    bit         prev_wr = 0;
    bit         b2b_seen = 0;

    always #2 clk = ~clk;

    gsw_monitor u_gsw_monitor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_sync(frame_sync),
        .slot_valid(slot_valid), .slot_idx(slot_idx), .mux_sel(mux_sel),
        .slot_data(slot_data), .irq_mask(irq_mask), .clr_valid(clr_valid),
        .clr_bits(clr_bits), .st_wr(st_wr), .st_chan(st_chan), .st_word(st_word),
        .pending(pending), .irq(irq)
    );

    always @(negedge clk) begin
        if (rst_n && st_wr) begin
            wr_cnt[st_chan]++;
            wr_word[st_chan] = int'(st_word);
            if (prev_wr && prev_chan != st_chan) b2b_seen = 1;
        end
        prev_wr   = rst_n && st_wr;
        prev_chan = st_chan;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            slot_valid = 0; frame_sync = 0; clr_valid = 0;
        end
    endtask

    // one frame: sync pulse, then all 32 slots of both multiplexes interleaved
    task automatic send_frame(input bit with_slots, input int seed);
        @(posedge clk); #1;
        frame_sync = 1; slot_valid = 0;
        @(posedge clk); #1;
        frame_sync = 0;
        if (with_slots) begin
            for (int s = 0; s < 32; s++) begin
                for (int m = 0; m < 2; m++) begin
                    slot_valid = 1;
                    slot_idx   = 5'(s);
                    mux_sel    = 1'(m);
                    if (s % 4 == 3)
                        slot_data = {cur_w[m*8 + s/4], 2'(s + seed)};
                    else
                        slot_data = 8'((s * 37 + m * 91 + seed * 13) & 255);
                    @(posedge clk); #1;
                end
            end
        end
        slot_valid = 0;
        idle(3);
    endtask

    task automatic expect_accept();
        for (int c = 0; c < 16; c++) begin
            exp_cnt[c]++;
            exp_word[c] = int'(cur_w[c]);
        end
    endtask

    task automatic check_writes(input string req);
        @(negedge clk);
        for (int c = 0; c < 16; c++) begin
            chk(wr_cnt[c] == exp_cnt[c], req, wr_cnt[c], exp_cnt[c]);
            if (exp_cnt[c] > 0)
                chk(wr_word[c] == exp_word[c], req, wr_word[c], exp_word[c]);
        end
    endtask

    task automatic clear(input logic [15:0] bits);
        @(posedge clk); #1;
        clr_valid = 1; clr_bits = bits;
        @(posedge clk); #1;
        clr_valid = 0; clr_bits = '0;
        idle(1);
    endtask

    initial begin
        for (int c = 0; c < 16; c++) begin
            wr_cnt[c] = 0; wr_word[c] = 0; exp_cnt[c] = 0; exp_word[c] = 0; cur_w[c] = '0;
        end
        idle(3);
        @(negedge clk);
        chk(st_wr == 0, "R9 st_wr", int'(st_wr), 0);
        chk(pending == 0, "R9 pending", int'(pending), 0);
        chk(irq == 0, "R9 irq", int'(irq), 0);
        rst_n = 1; enable = 1;
        idle(2);

        // R4: zero equals the reset value of the last accepted word
        send_frame(1, 1); send_frame(1, 2);
        check_writes("R4 zero after reset");

        // R3 first frame alone is not enough; R1 R2 R5 R10 on the second
        for (int c = 0; c < 16; c++) cur_w[c] = 6'((c * 3 + 5) & 63);
        send_frame(1, 3);
        check_writes("R3 single frame");
        send_frame(1, 4);
        expect_accept();
        check_writes("R1 R2 R5 accept");
        chk(b2b_seen, "R10 back-to-back writes", int'(b2b_seen), 1);
        chk(pending == 16'hFFFF, "R7 pending set", int'(pending), 16'hFFFF);
        chk(irq == 1, "R8 irq unmasked", int'(irq), 1);

        // R4: steady value, no repeat
        send_frame(1, 5);
        check_writes("R4 steady value");

        // R7 partial clear, R8 masking
        clear(16'h00FF);
        chk(pending == 16'hFF00, "R7 w1c", int'(pending), 16'hFF00);
        irq_mask = 16'hFF00; idle(1);
        chk(irq == 0, "R8 masked", int'(irq), 0);
        irq_mask = 16'h7F00; idle(1);
        chk(irq == 1, "R8 one unmasked", int'(irq), 1);
        irq_mask = 16'hFFFF;
        clear(16'hFFFF);
        chk(pending == 0, "R7 clear all", int'(pending), 0);

        // R3 alternating values: B, A, B, then B again accepts
        for (int c = 0; c < 16; c++) cur_w[c] = 6'((c * 3 + 6) & 63);
        send_frame(1, 6);
        for (int c = 0; c < 16; c++) cur_w[c] = 6'((c * 3 + 5) & 63);
        send_frame(1, 7);
        for (int c = 0; c < 16; c++) cur_w[c] = 6'((c * 3 + 6) & 63);
        send_frame(1, 8);
        check_writes("R3 alternating");
        send_frame(1, 9);
        expect_accept();
        check_writes("R3 second match");
        chk(pending == 16'hFFFF, "R8 masked still pending", int'(pending), 16'hFFFF);
        chk(irq == 0, "R8 all masked", int'(irq), 0);
        clear(16'hFFFF);

        // R3 an empty frame breaks the pair
        for (int c = 0; c < 16; c++) cur_w[c] = 6'((c * 5 + 17) & 63);
        send_frame(1, 10); send_frame(0, 11); send_frame(1, 12);
        check_writes("R3 missing frame");
        send_frame(1, 13);
        expect_accept();
        check_writes("R3 after gap");
        clear(16'hFFFF);

        // R6 disabled: nothing, and samples are forgotten
        irq_mask = 16'h0000;
        enable = 0;
        for (int c = 0; c < 16; c++) cur_w[c] = 6'((c * 7 + 2) & 63);
        send_frame(1, 14); send_frame(1, 15);
        check_writes("R6 disabled");
        chk(pending == 0, "R6 no pending", int'(pending), 0);
        chk(irq == 0, "R6 no irq", int'(irq), 0);
        enable = 1;
        send_frame(1, 16);
        check_writes("R6 samples forgotten");
        send_frame(1, 17);
        expect_accept();
        check_writes("R6 re-enabled");
        chk(irq == 1, "R8 irq after reenable", int'(irq), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule